// File: doc/BRIEF.md
# Byte-Matrix Column Rotation Instruction Unit

This unit hangs off a processor's instruction datapath as a custom operation. Every call presents two 32-bit operands and an 8-bit selector for one clock, and one cycle later the unit raises a one-cycle completion strobe together with a 32-bit result. Software uses a series of calls to fill a 64-byte working state, viewed as an 8×8 matrix of bytes. One further call rotates every column of that matrix downward by a distance equal to its own column number, in a single cycle. Sixteen more calls then drain the state one 32-bit word at a time.

Byte (row r, column c) is state byte 8·r+c. A load call writes one whole row: the first operand carries columns 0 to 3 and the second operand carries columns 4 to 7, with the lower-numbered byte in the more significant position. Reads return 32-bit words in the same big-endian arrangement. Internal write and read indices advance on their own, so software never passes an address.

Top module: `colrot_ci_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `done` is 0 and `result` is 0, both indices are 0 and every state byte is 0.
- R2: A call is a cycle with `start` high. `done` is high in the following cycle and in no other cycle, and `result` is valid in that same cycle.
- R3: Selector 0x00 (load) writes row k of the matrix, where k is the write index. `opa[31:24]`..`opa[7:0]` go to columns 0..3 and `opb[31:24]`..`opb[7:0]` go to columns 4..7. The write index then increments.
- R4: Selector 0x01 (permute) replaces the state in one call so that new[r][c] = old[(r−c) mod 8][c]. Column 0 is unchanged, and eight permutes restore the original state.
- R5: Selector 0x02 (read) returns word j, where j is the read index. Word j is made of state bytes 4j, 4j+1, 4j+2 and 4j+3, with byte 4j in bits 31:24. The read index then increments.
- R6: Selector 0x03 (clear) sets both indices to 0 and leaves the state unchanged.
- R7: Every call other than a read returns `result` = 0.
- R8: Selectors 0x04 to 0xFF change neither the state nor the indices, and they still complete with `done`.
- R9: Calls may be issued on consecutive cycles. Each call acts on the state and indices left by the call before it.
- R10: The write index wraps from 7 to 0 and the read index wraps from 15 to 0.
- R11: With `start` low, the selector and operands have no effect on state or indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Call strobe, one cycle per call |
| sel | input | 8 | Operation selector |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| result | output | 32 | Call result |
| done | output | 1 | Completion strobe, one cycle after the call |

## Verification
The cycle that shows one call's `done` and result is also the cycle in which the next call can be issued. A permute can therefore be followed directly by a clear and then by sixteen back-to-back reads. In the same way, a load can be issued while the previous read's result is still being presented. The bench keeps `start` high over such runs and compares every returned word against a byte-matrix model that it updates call by call. A stale or early view of the state would show up as a wrong word at a known position.

// File: rtl/colrot_pkg.sv
package colrot_pkg;

  localparam int SEL_W = 8;

  typedef enum logic [SEL_W-1:0] {
    OP_LOAD  = 8'h00,
    OP_PERM  = 8'h01,
    OP_READ  = 8'h02,
    OP_CLEAR = 8'h03
  } op_e;

  typedef struct packed {
    logic load;
    logic perm;
    logic read;
    logic clear;
  } op_dec_t;

endpackage

// File: rtl/colrot_decode.sv
module colrot_decode
  import colrot_pkg::*;
(
  input  logic             start,
  input  logic [SEL_W-1:0] sel,
  output op_dec_t          dec
);

  always_comb begin
    dec = '0;
    if (start) begin
      unique case (sel)
        OP_LOAD:  dec.load  = 1'b1;
        OP_PERM:  dec.perm  = 1'b1;
        OP_READ:  dec.read  = 1'b1;
        OP_CLEAR: dec.clear = 1'b1;
        default:  dec       = '0;
      endcase
    end
  end

endmodule

// File: rtl/colrot_index_ctrl.sv
module colrot_index_ctrl #(
  parameter int ROWS  = 8,
  parameter int WORDS = 16,
  localparam int PIDX_W = $clog2(ROWS),
  localparam int RIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              read_en,
  input  logic              clear_en,
  input  logic              start,
  output logic [PIDX_W-1:0] widx,
  output logic [RIDX_W-1:0] ridx
);

  localparam logic [PIDX_W-1:0] W_LAST = PIDX_W'(ROWS - 1);
  localparam logic [RIDX_W-1:0] R_LAST = RIDX_W'(WORDS - 1);

  logic [PIDX_W-1:0] widx_q, widx_d;
  logic [RIDX_W-1:0] ridx_q, ridx_d;
  logic              idx_en;

  assign idx_en = load_en | read_en | clear_en;

  always_comb begin
    widx_d = widx_q;
    ridx_d = ridx_q;
    if (clear_en) begin
      widx_d = '0;
      ridx_d = '0;
    end else begin
      if (load_en) widx_d = (widx_q == W_LAST) ? '0 : widx_q + 1'b1;
      if (read_en) ridx_d = (ridx_q == R_LAST) ? '0 : ridx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      widx_q <= '0;
      ridx_q <= '0;
    end else if (idx_en) begin
      widx_q <= widx_d;
      ridx_q <= ridx_d;
    end
  end

  assign widx = widx_q;
  assign ridx = ridx_q;

  // R3 / R10: a load moves the write index on by one, wrapping
  p_widx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (widx_q == $past(widx_q) + 1'b1));

  // R5 / R10: a read moves the read index on by one, wrapping
  p_ridx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    read_en |=> (ridx_q == $past(ridx_q) + 1'b1));

  // R6: clear returns both indices to zero
  p_clear_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (widx_q == '0 && ridx_q == '0));

  // R11: no call, no index movement
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(widx_q) && $stable(ridx_q)));

endmodule

// File: rtl/colrot_permute.sv
module colrot_permute #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int BYTE_W = 8,
  localparam int ST_W  = ROWS * COLS * BYTE_W
) (
  input  logic [ST_W-1:0] st_in,
  output logic [ST_W-1:0] st_out
);

  // destination (r,c) takes source ((r - c) mod ROWS, c)
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int SRC_R = (r + ROWS * COLS - c) % ROWS;
      assign st_out[(r * COLS + c) * BYTE_W +: BYTE_W] =
             st_in[(SRC_R * COLS + c) * BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/colrot_matrix_store.sv
module colrot_matrix_store #(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32,
  localparam int ST_W   = ROWS * COLS * BYTE_W,
  localparam int BPW    = WORD_W / BYTE_W,
  localparam int PIDX_W = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              perm_en,
  input  logic [PIDX_W-1:0] widx,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic [ST_W-1:0]   state
);

  logic [ST_W-1:0]   st_q, st_d, st_perm;
  logic [BYTE_W-1:0] row_bytes [COLS];
  logic              st_en;

  colrot_permute #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .BYTE_W (BYTE_W)
  ) u_perm (
    .st_in  (st_q),
    .st_out (st_perm)
  );

  // split the operand pair into one row, lower column in the higher byte
  for (genvar c = 0; c < COLS; c++) begin : g_split
    if (c < BPW) begin : g_a
      assign row_bytes[c] = opa[(BPW - 1 - c) * BYTE_W +: BYTE_W];
    end else begin : g_b
      assign row_bytes[c] = opb[(2 * BPW - 1 - c) * BYTE_W +: BYTE_W];
    end
  end

  assign st_en = load_en | perm_en;

  always_comb begin
    st_d = st_q;
    if (perm_en) begin
      st_d = st_perm;
    end else if (load_en) begin
      for (int c = 0; c < COLS; c++) begin
        st_d[(int'(widx) * COLS + c) * BYTE_W +: BYTE_W] = row_bytes[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign state = st_q;

  // column 0 gathered for the checks below
  logic [ROWS*BYTE_W-1:0] col0;
  for (genvar r = 0; r < ROWS; r++) begin : g_col0
    assign col0[r * BYTE_W +: BYTE_W] = st_q[r * COLS * BYTE_W +: BYTE_W];
  end

  localparam int B01 = 1;
  localparam int B11 = COLS + 1;

  // R4: column 0 has rotation zero and keeps its bytes
  p_col0_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perm_en |=> $stable(col0));

  // R4: column 1 moves down one row
  p_col1_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    perm_en |=> (st_q[B11 * BYTE_W +: BYTE_W] == $past(st_q[B01 * BYTE_W +: BYTE_W])));

  // R3: the first byte of the loaded row comes from the top byte of opa
  p_load_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && widx == '0) |=> (st_q[BYTE_W-1:0] == $past(opa[WORD_W-1 -: BYTE_W])));

endmodule

// File: rtl/colrot_ci_unit.sv
module colrot_ci_unit
  import colrot_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 8,
  parameter int BYTE_W = 8,
  parameter int WORD_W = 32,
  localparam int ST_W   = ROWS * COLS * BYTE_W,
  localparam int BPW    = WORD_W / BYTE_W,
  localparam int WORDS  = ROWS * COLS / BPW,
  localparam int PIDX_W = $clog2(ROWS),
  localparam int RIDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  output logic [WORD_W-1:0] result,
  output logic              done
);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  op_dec_t           dec;
  logic [PIDX_W-1:0] widx;
  logic [RIDX_W-1:0] ridx;
  logic [ST_W-1:0]   state;
  logic [WORD_W-1:0] rd_word, res_d, res_q;
  logic              done_q;

  colrot_decode u_dec (
    .start (start),
    .sel   (sel),
    .dec   (dec)
  );

  colrot_index_ctrl #(
    .ROWS  (ROWS),
    .WORDS (WORDS)
  ) u_idx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (dec.load),
    .read_en  (dec.read),
    .clear_en (dec.clear),
    .start    (start),
    .widx     (widx),
    .ridx     (ridx)
  );

  colrot_matrix_store #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .BYTE_W (BYTE_W),
    .WORD_W (WORD_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (dec.load),
    .perm_en (dec.perm),
    .widx    (widx),
    .opa     (opa),
    .opb     (opb),
    .state   (state)
  );

  // word select, first byte of the word in the top byte lane
  always_comb begin
    rd_word = '0;
    for (int j = 0; j < BPW; j++) begin
      rd_word[(BPW - 1 - j) * BYTE_W +: BYTE_W] =
        state[(int'(ridx) * BPW + j) * BYTE_W +: BYTE_W];
    end
  end

  assign res_d = dec.read ? rd_word : '0;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= start;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  // R2: every call completes on the next cycle
  p_done_follows_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    start |=> done);

  // R2: no strobe without a call
  p_done_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start |=> !done);

  // R7 / R8: non-read calls answer zero
  p_nonread_zero_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && sel != OP_READ) |=> (result == '0));

  // R8: unknown selectors leave the matrix alone
  p_unknown_hold_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && sel > OP_CLEAR) |=> $stable(state));

endmodule

// File: tb/colrot_ci_unit_test.sv
`timescale 1ns/1ps
module colrot_ci_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  sel;
  logic [31:0] opa, opb;
  logic [31:0] result;
  logic        done;

  always #2.5 clk = ~clk;

  colrot_ci_unit uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .sel    (sel),
    .opa    (opa),
    .opb    (opb),
    .result (result),
    .done   (done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // bench model of the matrix and indices
  logic [7:0]  mb [64];
  int          mw, mr;
  bit          pend_valid;
  logic [31:0] pend_res;
  string       pend_tag;

  function automatic logic [31:0] model_word(int w);
    return {mb[4*w], mb[4*w+1], mb[4*w+2], mb[4*w+3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    if (pend_valid) begin
      chk(done === 1'b1, "R2 done after call", {31'b0, done}, 32'h1);
      chk(result === pend_res, pend_tag, result, pend_res);
    end else begin
      chk(done === 1'b0, "R2 done without call", {31'b0, done}, 32'h0);
    end
  endtask

  task automatic do_call(input logic [7:0] s, input logic [31:0] a, input logic [31:0] b);
    logic [7:0] tmp [64];
    @(negedge clk);
    check_pending();
    start = 1'b1; sel = s; opa = a; opb = b;
    pend_valid = 1'b1;
    pend_res   = 32'h0;
    case (s)
      8'h00: begin
        pend_tag = "R3/R7 load result";
        for (int k = 0; k < 4; k++) begin
          mb[8*mw+k]   = a[31-8*k -: 8];
          mb[8*mw+4+k] = b[31-8*k -: 8];
        end
        mw = (mw + 1) % 8;
      end
      8'h01: begin
        pend_tag = "R4/R7 permute result";
        for (int r = 0; r < 8; r++)
          for (int c = 0; c < 8; c++)
            tmp[((r + c) % 8) * 8 + c] = mb[r*8+c];
        for (int k = 0; k < 64; k++) mb[k] = tmp[k];
      end
      8'h02: begin
        pend_tag = "R5/R4/R9 read word";
        pend_res = model_word(mr);
        mr = (mr + 1) % 16;
      end
      8'h03: begin
        pend_tag = "R6/R7 clear result";
        mw = 0; mr = 0;
      end
      default: pend_tag = "R8 unknown selector result";
    endcase
  endtask

  task automatic idle(input logic [7:0] s, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    check_pending();
    start = 1'b0; sel = s; opa = a; opb = b;
    pend_valid = 1'b0;
  endtask

  // {is_call, sel, opa, opb}
  localparam int NV = 44;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h03, 32'h0, 32'h0},
    {1'b1, 8'h00, 32'h00010203, 32'h04050607},
    {1'b1, 8'h00, 32'h08090a0b, 32'h0c0d0e0f},
    {1'b1, 8'h00, 32'h10111213, 32'h14151617},
    {1'b1, 8'h00, 32'h18191a1b, 32'h1c1d1e1f},
    {1'b1, 8'h00, 32'h20212223, 32'h24252627},
    {1'b1, 8'h00, 32'h28292a2b, 32'h2c2d2e2f},
    {1'b1, 8'h00, 32'h30313233, 32'h34353637},
    {1'b1, 8'h00, 32'h38393a3b, 32'h3c3d3e3f},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0},
    {1'b1, 8'h01, 32'h12345678, 32'h9abcdef0},
    {1'b1, 8'h03, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h7e, 32'hffffffff, 32'hffffffff},
    {1'b1, 8'hff, 32'ha5a5a5a5, 32'h5a5a5a5a},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h00, 32'hdeadbeef, 32'hcafef00d},
    {1'b1, 8'h03, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b1, 8'h00, 32'h11223344, 32'h55667788},
    {1'b1, 8'h01, 32'h0, 32'h0},
    {1'b1, 8'h02, 32'h0, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'h0}
  };

  task automatic model_reset();
    for (int k = 0; k < 64; k++) mb[k] = 8'h00;
    mw = 0; mr = 0;
    pend_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; sel = 8'h00; opa = '0; opb = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(done === 1'b0, "R1 done in reset", {31'b0, done}, 32'h0);
    chk(result === 32'h0, "R1 result in reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (4) idle(8'h00, 32'h0, 32'h0);
    // R1: state reads zero after reset
    do_call(8'h02, '0, '0);
    do_call(8'h02, '0, '0);
    do_call(8'h03, '0, '0);

    // vector walk (R3 R4 R5 R6 R7 R8 R9 R10)
    foreach (VEC[i]) begin
      if (VEC[i][72]) do_call(VEC[i][71:64], VEC[i][63:32], VEC[i][31:0]);
      else            idle(VEC[i][71:64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R11: load selector with start low must not write
    idle(8'h00, 32'hffffffff, 32'hffffffff);
    idle(8'h02, 32'h0, 32'h0);
    do_call(8'h03, '0, '0);
    do_call(8'h02, '0, '0);
    do_call(8'h02, '0, '0);

    // R4: eight permutes give the identity
    for (int p = 0; p < 8; p++) do_call(8'h01, '0, '0);
    do_call(8'h03, '0, '0);
    for (int w = 0; w < 16; w++) do_call(8'h02, '0, '0);
    idle(8'h00, '0, '0);
    idle(8'h00, '0, '0);

    // R1: reset in the middle of a run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    chk(done === 1'b0, "R1 done after mid reset", {31'b0, done}, 32'h0);
    chk(result === 32'h0, "R1 result after mid reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (4) idle(8'h00, '0, '0);
    do_call(8'h02, '0, '0);
    do_call(8'h02, '0, '0);
    do_call(8'h00, 32'hfeedface, 32'h01234567);
    do_call(8'h03, '0, '0);
    do_call(8'h02, '0, '0);
    do_call(8'h02, '0, '0);
    idle(8'h00, '0, '0);
    idle(8'h00, '0, '0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule